// File: doc/BRIEF.md
# Register Bank Access Guard

This block sits beside the operand decode of an instruction pipeline and decides, once per cycle, whether the register-file accesses of the current instruction are allowed. It takes the privilege bit from the processor status register, up to three register operands (source A, source B and a destination, each with its own valid flag), and a write port for an internal bank-protection mask. In User mode, an access to a register whose 16-register bank is marked in the mask becomes a protection-violation trap request. Supervisor code then takes over.

Registers 0 and 1 are never checked against the mask. Supervisor-mode accesses are never blocked. Only Supervisor mode can change the mask. A User-mode write to the mask is dropped and is itself reported as a violation. The trap request, the index of the offending operand and its register number are registered outputs. They are valid in the cycle after the access and last for one cycle only.

The output side is a two-state machine. `ST_QUIET` means no trap is being signalled. `ST_FLAG` means a trap request is presented. The transitions are:
- QUIET→FLAG when a violation is detected.
- FLAG→FLAG when the next access also violates.
- FLAG→QUIET and QUIET→QUIET when no violation is detected.

Top module: `rbp_guard`

## Requirements
- R1: When `sup_mode` is 1 the block is in Supervisor mode. In Supervisor mode no operand access and no mask write ever raises `trap_req`.
- R2: The bank of a register is its number divided by 16. In User mode (`sup_mode`=0), a valid operand whose bank has its mask bit set produces a trap.
- R3: With a mask of 0x3F, User-mode accesses to registers 96..127 pass, and accesses to registers 2..95 trap.
- R4: User-mode accesses to registers 0 and 1 never trap, whatever the mask. A reported operand register number is therefore always 2 or more.
- R5: An operand whose valid flag is 0 is never checked. With no valid operand and no mask write, no trap follows.
- R6: When several operands violate in the same cycle, the lowest index wins. The encoding of `trap_opnd` is source A = 0, source B = 1, destination = 2, and a denied mask write = 3. `trap_reg` carries the offending operand's register number.
- R7: A violation in cycle t shows on `trap_req`, `trap_opnd` and `trap_reg` only in cycle t+1. If cycle t+1 has no violation, `trap_req` is 0 in cycle t+2.
- R8: After reset the mask is 0x00, meaning no bank is protected, and `trap_req`, `trap_opnd` and `trap_reg` are 0.
- R9: A mask write with `sup_mode`=1 loads `mask_wdata`. The new mask governs accesses from the next cycle on.
- R10: A mask write with `sup_mode`=0 leaves the mask unchanged and traps with `trap_opnd`=3 and `trap_reg`=0. If an operand violates in the same cycle, the operand is reported instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_mode | input | 1 | Privilege bit: 1 = Supervisor, 0 = User |
| src_a_vld | input | 1 | Source A operand present |
| src_a_num | input | 7 | Source A register number |
| src_b_vld | input | 1 | Source B operand present |
| src_b_num | input | 7 | Source B register number |
| dst_vld | input | 1 | Destination operand present |
| dst_num | input | 7 | Destination register number |
| mask_we | input | 1 | Write strobe for the protection mask |
| mask_wdata | input | 8 | New mask value, with bit n covering bank n |
| trap_req | output | 1 | Protection-violation trap request |
| trap_opnd | output | 2 | Offending operand index |
| trap_reg | output | 7 | Offending register number |

## Verification
Some rules can be checked on every cycle:
- Supervisor cycles and cycles with nothing to check are never followed by a trap.
- A denied mask write is always followed by a trap that reports index 3 with register 0.
- A reported register is never one of the exempt pair.
- A source-A report always carries the register number from the previous cycle.

Other behaviour needs the bench's scenarios, because it shows only through what follows:
- that a denied write really left the mask untouched;
- that a granted write governs later cycles;
- the priority among several violating operands;
- the exact bank boundaries at 0x3F.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
    localparam int unsigned NUM_OPND = 3;
    localparam int unsigned IDX_W    = 2;

    localparam logic [IDX_W-1:0] IDX_SRC_A  = 2'd0;
    localparam logic [IDX_W-1:0] IDX_SRC_B  = 2'd1;
    localparam logic [IDX_W-1:0] IDX_DST    = 2'd2;
    localparam logic [IDX_W-1:0] IDX_MASKWR = 2'd3;

    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_FLAG  = 1'b1
    } trap_st_t;
endpackage

// File: rtl/rbp_mask_reg.sv
module rbp_mask_reg #(
    parameter int unsigned NBANK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sup_mode,
    input  logic             wr_en,
    input  logic [NBANK-1:0] wr_data,
    output logic [NBANK-1:0] mask,
    output logic             wr_denied
);
    // Only privileged writes land; the reset value leaves every bank open.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= '0;
        else if (wr_en && sup_mode)
            mask <= wr_data;
    end

    assign wr_denied = wr_en && !sup_mode;
endmodule

// File: rtl/rbp_opnd_chk.sv
module rbp_opnd_chk #(
    parameter int unsigned RW          = 7,
    parameter int unsigned BANK_SIZE   = 16,
    parameter int unsigned NBANK       = 8,
    parameter int unsigned EXEMPT_REGS = 2
) (
    input  logic             vld,
    input  logic [RW-1:0]    num,
    input  logic             user,
    input  logic [NBANK-1:0] mask,
    output logic             hit
);
    localparam int unsigned BSH = $clog2(BANK_SIZE);
    localparam int unsigned BIW = RW - BSH;

    logic [BIW-1:0] bank_idx;
    logic           exempt;

    assign bank_idx = num[RW-1:BSH];
    assign exempt   = (num < RW'(EXEMPT_REGS));
    assign hit      = vld && user && !exempt && mask[bank_idx];
endmodule

// File: rtl/rbp_pick.sv
module rbp_pick
    import rbp_pkg::*;
#(
    parameter int unsigned RW = 7
) (
    input  logic [NUM_OPND-1:0]         hit,
    input  logic [NUM_OPND-1:0][RW-1:0] nums,
    input  logic                        mw_deny,
    output logic                        any,
    output logic [IDX_W-1:0]            idx,
    output logic [RW-1:0]               rnum
);
    always_comb begin
        // A denied mask write is the fallback report; operand hits override it.
        idx  = mw_deny ? IDX_MASKWR : IDX_SRC_A;
        rnum = '0;
        // Walk downward so that the lowest operand index is kept.
        for (int i = NUM_OPND - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx  = IDX_W'(i);
                rnum = nums[i];
            end
        end
        any = (|hit) || mw_deny;
    end
endmodule

// File: rtl/rbp_guard.sv
module rbp_guard
    import rbp_pkg::*;
#(
    parameter int unsigned NREGS       = 128,
    parameter int unsigned BANK_SIZE   = 16,
    parameter int unsigned EXEMPT_REGS = 2,
    localparam int unsigned RW         = $clog2(NREGS),
    localparam int unsigned NBANK      = NREGS / BANK_SIZE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sup_mode,
    input  logic             src_a_vld,
    input  logic [RW-1:0]    src_a_num,
    input  logic             src_b_vld,
    input  logic [RW-1:0]    src_b_num,
    input  logic             dst_vld,
    input  logic [RW-1:0]    dst_num,
    input  logic             mask_we,
    input  logic [NBANK-1:0] mask_wdata,
    output logic             trap_req,
    output logic [IDX_W-1:0] trap_opnd,
    output logic [RW-1:0]    trap_reg
);
    logic [NBANK-1:0]            mask;
    logic                        mw_deny;
    logic [NUM_OPND-1:0]         vlds;
    logic [NUM_OPND-1:0][RW-1:0] nums;
    logic [NUM_OPND-1:0]         hit;
    logic                        viol;
    logic [IDX_W-1:0]            viol_idx;
    logic [RW-1:0]               viol_reg;
    trap_st_t                    state, state_nxt;

    assign vlds = {dst_vld, src_b_vld, src_a_vld};
    assign nums = {dst_num, src_b_num, src_a_num};

    rbp_mask_reg #(.NBANK(NBANK)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .sup_mode  (sup_mode),
        .wr_en     (mask_we),
        .wr_data   (mask_wdata),
        .mask      (mask),
        .wr_denied (mw_deny)
    );

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        rbp_opnd_chk #(
            .RW          (RW),
            .BANK_SIZE   (BANK_SIZE),
            .NBANK       (NBANK),
            .EXEMPT_REGS (EXEMPT_REGS)
        ) u_chk (
            .vld  (vlds[g]),
            .num  (nums[g]),
            .user (!sup_mode),
            .mask (mask),
            .hit  (hit[g])
        );
    end

    rbp_pick #(.RW(RW)) u_pick (
        .hit     (hit),
        .nums    (nums),
        .mw_deny (mw_deny),
        .any     (viol),
        .idx     (viol_idx),
        .rnum    (viol_reg)
    );

    // Next-state decision.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_QUIET: state_nxt = viol ? ST_FLAG : ST_QUIET;
            ST_FLAG:  state_nxt = viol ? ST_FLAG : ST_QUIET;
            default:  state_nxt = ST_QUIET;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_QUIET;
        else
            state <= state_nxt;
    end

    // Report registers: loaded on a violation, cleared otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trap_opnd <= '0;
            trap_reg  <= '0;
        end else if (viol) begin
            trap_opnd <= viol_idx;
            trap_reg  <= viol_reg;
        end else begin
            trap_opnd <= '0;
            trap_reg  <= '0;
        end
    end

    assign trap_req = (state == ST_FLAG);
endmodule

// File: rtl/rbp_guard_chk.sv
module rbp_guard_chk #(
    parameter int unsigned RW          = 7,
    parameter int unsigned EXEMPT_REGS = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sup_mode,
    input logic          src_a_vld,
    input logic [RW-1:0] src_a_num,
    input logic          src_b_vld,
    input logic          dst_vld,
    input logic          mask_we,
    input logic          trap_req,
    input logic [1:0]    trap_opnd,
    input logic [RW-1:0] trap_reg
);
    // R1
    sup_never_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sup_mode |=> !trap_req);

    // R5
    idle_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_a_vld && !src_b_vld && !dst_vld && !mask_we) |=> !trap_req);

    // R10
    user_maskwr_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_mode && mask_we) |=> trap_req);

    // R10
    maskwr_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_opnd == 2'd3) |->
            (trap_reg == '0 && $past(mask_we) && !$past(sup_mode)));

    // R4
    exempt_never_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_opnd != 2'd3) |-> (trap_reg >= RW'(EXEMPT_REGS)));

    // R6
    src_a_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_opnd == 2'd0) |-> (trap_reg == $past(src_a_num) && $past(src_a_vld)));

    // R8
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> (trap_opnd == 2'd0 && trap_reg == '0));
endmodule

bind rbp_guard rbp_guard_chk #(.RW(RW), .EXEMPT_REGS(EXEMPT_REGS)) u_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_mode  (sup_mode),
    .src_a_vld (src_a_vld),
    .src_a_num (src_a_num),
    .src_b_vld (src_b_vld),
    .dst_vld   (dst_vld),
    .mask_we   (mask_we),
    .trap_req  (trap_req),
    .trap_opnd (trap_opnd),
    .trap_reg  (trap_reg)
);

// File: tb/rbp_guard_test.sv
module rbp_guard_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sup_mode = 1'b0;
    logic       src_a_vld = 1'b0, src_b_vld = 1'b0, dst_vld = 1'b0;
    logic [6:0] src_a_num = '0, src_b_num = '0, dst_num = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       trap_req;
    logic [1:0] trap_opnd;
    logic [6:0] trap_reg;

    int total = 0;
    int bad = 0;
    logic [7:0] mdl_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbp_guard uut (
        .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode),
        .src_a_vld(src_a_vld), .src_a_num(src_a_num),
        .src_b_vld(src_b_vld), .src_b_num(src_b_num),
        .dst_vld(dst_vld), .dst_num(dst_num),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .trap_req(trap_req), .trap_opnd(trap_opnd), .trap_reg(trap_reg)
    );

    function automatic logic opnd_bad(logic sup, logic v, logic [6:0] n, logic [7:0] m);
        return !sup && v && (n >= 7'd2) && m[n[6:4]];
    endfunction

    // Expected trap report for one access: {trap, idx, reg}
    function automatic logic [9:0] expect_of(logic sup, logic av, logic [6:0] an,
                                             logic bv, logic [6:0] bn, logic dv,
                                             logic [6:0] dn, logic we, logic [7:0] m);
        if (opnd_bad(sup, av, an, m)) return {1'b1, 2'd0, an};
        if (opnd_bad(sup, bv, bn, m)) return {1'b1, 2'd1, bn};
        if (opnd_bad(sup, dv, dn, m)) return {1'b1, 2'd2, dn};
        if (we && !sup)               return {1'b1, 2'd3, 7'd0};
        return 10'd0;
    endfunction

    task automatic check(string tag, logic [9:0] exp);
        logic [9:0] act;
        act = {trap_req, trap_opnd, trap_reg};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got req=%0b idx=%0d reg=%0d, expected req=%0b idx=%0d reg=%0d",
                     tag, act[9], act[8:7], act[6:0], exp[9], exp[8:7], exp[6:0]);
        end
    endtask

    // Drive one access at a falling edge, check its report one full cycle later.
    task automatic access(string tag, logic sup, logic av, logic [6:0] an,
                          logic bv, logic [6:0] bn, logic dv, logic [6:0] dn,
                          logic we, logic [7:0] wd);
        logic [9:0] exp;
        sup_mode = sup; src_a_vld = av; src_a_num = an; src_b_vld = bv; src_b_num = bn;
        dst_vld = dv; dst_num = dn; mask_we = we; mask_wdata = wd;
        exp = expect_of(sup, av, an, bv, bn, dv, dn, we, mdl_mask);
        if (we && sup) mdl_mask = wd;
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic idle(string tag);
        access(tag, 1'b0, 1'b0, 7'd0, 1'b0, 7'd0, 1'b0, 7'd0, 1'b0, 8'd0);
    endtask

    task automatic user_rd(string tag, logic [6:0] n);
        access(tag, 1'b0, 1'b1, n, 1'b0, 7'd0, 1'b0, 7'd0, 1'b0, 8'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd1995;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 reset outputs", 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 mask resets open: protected-range access passes
        user_rd("R8 open after reset", 7'd50);
        user_rd("R8 open after reset hi", 7'd5);

        // R9 privileged write, effective next cycle
        access("R9 sup write", 1'b1, 1'b0, 7'd0, 1'b0, 7'd0, 1'b0, 7'd0, 1'b1, 8'h3F);
        // R3 boundaries
        user_rd("R3 reg 95 traps", 7'd95);
        user_rd("R3 reg 96 passes", 7'd96);
        user_rd("R3 reg 2 traps", 7'd2);
        user_rd("R3 reg 127 passes", 7'd127);
        // R4 exempt pair
        user_rd("R4 reg 1 exempt", 7'd1);
        user_rd("R4 reg 0 exempt", 7'd0);
        // R5 invalid operands ignored
        access("R5 invalid ops", 1'b0, 1'b0, 7'd20, 1'b0, 7'd30, 1'b0, 7'd40, 1'b0, 8'd0);
        // R6 priority
        access("R6 all violate", 1'b0, 1'b1, 7'd10, 1'b1, 7'd20, 1'b1, 7'd30, 1'b0, 8'd0);
        access("R6 b and dst", 1'b0, 1'b1, 7'd100, 1'b1, 7'd21, 1'b1, 7'd31, 1'b0, 8'd0);
        access("R6 dst only", 1'b0, 1'b1, 7'd1, 1'b1, 7'd110, 1'b1, 7'd33, 1'b0, 8'd0);
        // R7 single-cycle pulse
        idle("R7 pulse ends");
        // R1 supervisor unrestricted
        access("R1 sup access", 1'b1, 1'b1, 7'd10, 1'b1, 7'd20, 1'b1, 7'd30, 1'b0, 8'd0);
        // R10 denied write, then mask still 0x3F
        access("R10 user write", 1'b0, 1'b0, 7'd0, 1'b0, 7'd0, 1'b0, 7'd0, 1'b1, 8'h00);
        user_rd("R10 mask kept", 7'd50);
        access("R10 operand wins", 1'b0, 1'b0, 7'd0, 1'b1, 7'd64, 1'b0, 7'd0, 1'b1, 8'h00);
        // R2 single bank
        access("R2 set bank 7", 1'b1, 1'b0, 7'd0, 1'b0, 7'd0, 1'b0, 7'd0, 1'b1, 8'h80);
        user_rd("R2 bank 7 traps", 7'd112);
        user_rd("R2 bank 6 passes", 7'd111);
        idle("R7 idle");

        // R2 R6 R7 R9 R10 random mix
        for (int i = 0; i < 4000; i++) begin
            logic sup, we;
            sup = ($urandom % 4) == 0;
            we  = ($urandom % 8) == 0;
            access("R2 R6 R7 R9 R10 random", sup,
                   1'($urandom), 7'($urandom), 1'($urandom), 7'($urandom),
                   1'($urandom), 7'($urandom), we, 8'($urandom));
        end
        idle("R7 final");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule